// File: doc/BRIEF.md
# USB Host Functional State Controller

This block owns the main control word of a USB host controller and the two-bit functional state machine kept inside it. Software writes the whole word through a simple write port and reads it back on a parallel bus. The block then drives the current state, the list enables and the service ratio to the rest of the host, routes the host's interrupt request to one of two outputs, and raises a remote wakeup signal.

A hardware reset and a software reset strobe both leave the machine in a known state, but not the same one. After a hardware reset the state is reset, every bit is clear, and downstream ports are asked to signal reset. A software reset moves the state to suspend and keeps the two ownership bits. Start-of-frame generation begins a timed millisecond after the state enters operational. A status bit records the first start-of-frame so that software can poll for it. The isochronous enable reaches the list engine only at a frame boundary.

Top module: `hcfs_ctrl`

## Requirements
- R1: A write stores its low 11 bits as fields in this layout: service ratio [1:0], periodic enable 2, control enable 3, isochronous enable 4, bulk enable 5, state [7:6], interrupt routing 8, wakeup-connected 9, wakeup enable 10. A read returns these bits, plus the read-only frame-started flag at bit 11, and zero above bit 11.
- R2: A hardware reset (rst_n low) clears every bit, so rd_data reads 0 and the state is 0 (reset). port_reset_req is 1 whenever the state is 0.
- R3: A software reset sets the state to 3 (suspend), keeps bits 8 and 9, and clears every other field, the frame-started flag and the applied isochronous enable. It takes priority over a write in the same cycle.
- R4: State codes are 0 reset, 1 resume, 2 operational and 3 suspend. Without a write or a reset, the state changes only from 3 to 1, and only when a downstream resume detection has come through the RESUME_SYNC-stage synchroniser. A write in the same cycle takes priority over that change.
- R5: sof_en rises exactly CYC_PER_MS clock cycles after func_state first reads 2. Writing 2 again while already operational does not restart the delay.
- R6: sof_en is 0 in every cycle that follows a cycle whose state is not 2. If the state leaves 2 before the delay ends, the pending start is cancelled.
- R7: Bit 11 is set in the same edge as sof_en rises. It stays set after the state leaves operational, and it is cleared by a write that moves the state into 2 from another state, or by either reset.
- R8: iso_en takes the stored bit 4 only in a cycle with frame_edge high. At other times it holds its value.
- R9: irq_req goes to irq_host when bit 8 is 0 and to irq_smi when bit 8 is 1. The other output stays 0.
- R10: remote_wake is high exactly when bit 10 and resume_status are both 1. Bit 10 does not affect irq_host or irq_smi.
- R11: svc_ratio, per_en, ctl_en and blk_en follow the stored bits [1:0], 2, 3 and 5 in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| sw_rst | input | 1 | Software reset strobe |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word write value |
| port_resume_det | input | 1 | Resume signalling seen on a downstream port |
| resume_status | input | 1 | Resume-detected status bit |
| irq_req | input | 1 | Interrupt request from the status logic |
| frame_edge | input | 1 | Frame boundary pulse |
| rd_data | output | DATA_W | Control word readback |
| func_state | output | 2 | Current functional state |
| sof_en | output | 1 | Start-of-frame generation enable |
| port_reset_req | output | 1 | Reset signalling request to downstream ports |
| remote_wake | output | 1 | Remote wakeup to the host system |
| irq_host | output | 1 | Normal host interrupt |
| irq_smi | output | 1 | System management interrupt |
| svc_ratio | output | 2 | Control-to-bulk service ratio |
| per_en | output | 1 | Periodic list enable |
| ctl_en | output | 1 | Control list enable |
| blk_en | output | 1 | Bulk list enable |
| iso_en | output | 1 | Isochronous enable applied at a frame boundary |

## Verification
A behavioural model in the bench follows the block on every clock. The bench drives several kinds of stimulus:
- A full entry into operational, which measures the start delay to the exact cycle.
- A rewrite of operational while already operational, which shows whether the delay restarts.
- A short visit to operational, which shows whether a cancelled start leaks through.
- A software reset in the same cycle as a write, and a later hardware reset, which show the two resets to be different.
- A resume pulse while in suspend, which separates the one allowed self-driven transition from state drift.
- A frame-edge pulse, which separates the applied isochronous enable from the stored bit.

// File: rtl/hcfs_pkg.sv
package hcfs_pkg;
   typedef enum logic [1:0] {
      HS_RESET   = 2'd0,
      HS_RESUME  = 2'd1,
      HS_OPER    = 2'd2,
      HS_SUSPEND = 2'd3
   } hs_state_e;

   // field order is the readback bit order, most significant first
   typedef struct packed {
      logic       wake_en;
      logic       wake_conn;
      logic       route_smi;
      hs_state_e  st;
      logic       blk;
      logic       iso;
      logic       ctl;
      logic       per;
      logic [1:0] ratio;
   } hcfs_cfg_t;

   localparam int CFG_BITS = $bits(hcfs_cfg_t);
   localparam int REG_BITS = CFG_BITS + 1;
endpackage

// File: rtl/hcfs_resume_sync.sv
module hcfs_resume_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_sync
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= (sh << 1) | STAGES'(d);
         end
         assign q = sh[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/hcfs_regs.sv
module hcfs_regs
   import hcfs_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sw_rst,
   input  logic                wr_en,
   input  logic [CFG_BITS-1:0] wr_bits,
   input  logic                resume_evt,
   input  logic                frame_edge,
   output hcfs_cfg_t           cfg,
   output logic                iso_act
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg     <= '0;
         iso_act <= 1'b0;
      end else begin
         if (sw_rst) begin
            cfg.ratio   <= '0;
            cfg.per     <= 1'b0;
            cfg.ctl     <= 1'b0;
            cfg.iso     <= 1'b0;
            cfg.blk     <= 1'b0;
            cfg.wake_en <= 1'b0;
            cfg.st      <= HS_SUSPEND;
         end else if (wr_en) begin
            cfg <= hcfs_cfg_t'(wr_bits);
         end else if (cfg.st == HS_SUSPEND && resume_evt) begin
            cfg.st <= HS_RESUME;
         end

         if (sw_rst)          iso_act <= 1'b0;
         else if (frame_edge) iso_act <= cfg.iso;
      end
   end
endmodule

// File: rtl/hcfs_sof_timer.sv
module hcfs_sof_timer #(
   parameter int CYC_PER_MS = 125000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_oper,
   output logic sof_en,
   output logic sof_first
);
   localparam int CW = (CYC_PER_MS > 1) ? $clog2(CYC_PER_MS) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

   logic [CW-1:0] cnt;

   assign sof_first = in_oper && !sof_en && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         sof_en <= 1'b0;
      end else if (!in_oper) begin
         cnt    <= '0;
         sof_en <= 1'b0;
      end else if (sof_first) begin
         sof_en <= 1'b1;
      end else if (!sof_en) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/hcfs_ctrl.sv
module hcfs_ctrl
   import hcfs_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int CYC_PER_MS  = 125000,
   parameter int RESUME_SYNC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              port_resume_det,
   input  logic              resume_status,
   input  logic              irq_req,
   input  logic              frame_edge,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        func_state,
   output logic              sof_en,
   output logic              port_reset_req,
   output logic              remote_wake,
   output logic              irq_host,
   output logic              irq_smi,
   output logic [1:0]        svc_ratio,
   output logic              per_en,
   output logic              ctl_en,
   output logic              blk_en,
   output logic              iso_en
);
   generate
      if (DATA_W <= REG_BITS) begin : g_bad_width
         $error("DATA_W must exceed the control word width");
      end
      if (CYC_PER_MS < 1) begin : g_bad_ms
         $error("CYC_PER_MS must be at least 1");
      end
      if (RESUME_SYNC < 0) begin : g_bad_sync
         $error("RESUME_SYNC must not be negative");
      end
   endgenerate

   hcfs_cfg_t cfg;
   logic      iso_act;
   logic      resume_evt;
   logic      sof_first;
   logic      seen;
   logic      enter_oper;
   wire       unused_wr_hi = ^wr_data[DATA_W-1:CFG_BITS];

   hcfs_resume_sync #(.STAGES(RESUME_SYNC)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(port_resume_det), .q(resume_evt)
   );

   hcfs_regs i_regs (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en),
      .wr_bits(wr_data[CFG_BITS-1:0]), .resume_evt(resume_evt),
      .frame_edge(frame_edge), .cfg(cfg), .iso_act(iso_act)
   );

   hcfs_sof_timer #(.CYC_PER_MS(CYC_PER_MS)) i_timer (
      .clk(clk), .rst_n(rst_n), .in_oper(cfg.st == HS_OPER),
      .sof_en(sof_en), .sof_first(sof_first)
   );

   assign enter_oper = wr_en && !sw_rst &&
                       (hs_state_e'(wr_data[7:6]) == HS_OPER) && (cfg.st != HS_OPER);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     seen <= 1'b0;
      else if (sw_rst || enter_oper)  seen <= 1'b0;
      else if (sof_first)             seen <= 1'b1;
   end

   assign rd_data        = {{(DATA_W-REG_BITS){1'b0}}, seen, cfg};
   assign func_state     = cfg.st;
   assign port_reset_req = (cfg.st == HS_RESET);
   assign remote_wake    = cfg.wake_en & resume_status;
   assign irq_host       = irq_req & ~cfg.route_smi;
   assign irq_smi        = irq_req &  cfg.route_smi;
   assign svc_ratio      = cfg.ratio;
   assign per_en         = cfg.per;
   assign ctl_en         = cfg.ctl;
   assign blk_en         = cfg.blk;
   assign iso_en         = iso_act;
endmodule

// File: rtl/hcfs_ctrl_chk.sv
module hcfs_ctrl_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw_rst,
   input logic              wr_en,
   input logic              resume_evt,
   input logic              resume_status,
   input logic              irq_req,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        func_state,
   input logic              sof_en,
   input logic              remote_wake,
   input logic              irq_host,
   input logic              irq_smi
);
   p_swrst_suspend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> func_state == 2'd3);

   p_swrst_keep_own_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst |=> $stable(rd_data[9:8]));

   p_state_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_rst && !wr_en && !(func_state == 2'd3 && resume_evt)) |=> $stable(func_state));

   p_auto_resume_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (func_state == 2'd3 && resume_evt && !wr_en && !sw_rst) |=> func_state == 2'd1);

   p_sof_in_oper_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sof_en) |-> (func_state == 2'd2 && $past(func_state) == 2'd2));

   p_sof_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (func_state != 2'd2) |=> !sof_en);

   p_seen_with_sof_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sof_en) |-> rd_data[11]);

   p_route_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (irq_host != irq_smi));

   p_wake_needs_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      remote_wake |-> resume_status);
endmodule

bind hcfs_ctrl hcfs_ctrl_chk #(.DATA_W(DATA_W)) i_hcfs_chk (
   .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en),
   .resume_evt(resume_evt), .resume_status(resume_status), .irq_req(irq_req),
   .rd_data(rd_data), .func_state(func_state), .sof_en(sof_en),
   .remote_wake(remote_wake), .irq_host(irq_host), .irq_smi(irq_smi)
);

// File: tb/test_hcfs_ctrl.sv
module test_hcfs_ctrl;
   localparam int N = 20;

   logic        clk = 1'b0, rst_n = 1'b0, sw_rst = 1'b0, wr_en = 1'b0;
   logic        port_resume_det = 1'b0, resume_status = 1'b0, irq_req = 1'b0, frame_edge = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [1:0]  func_state, svc_ratio;
   logic        sof_en, port_reset_req, remote_wake, irq_host, irq_smi;
   logic        per_en, ctl_en, blk_en, iso_en;

   hcfs_ctrl #(.DATA_W(32), .CYC_PER_MS(N), .RESUME_SYNC(2)) i_hcfs_ctrl (
      .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .wr_en(wr_en), .wr_data(wr_data),
      .port_resume_det(port_resume_det), .resume_status(resume_status),
      .irq_req(irq_req), .frame_edge(frame_edge), .rd_data(rd_data),
      .func_state(func_state), .sof_en(sof_en), .port_reset_req(port_reset_req),
      .remote_wake(remote_wake), .irq_host(irq_host), .irq_smi(irq_smi),
      .svc_ratio(svc_ratio), .per_en(per_en), .ctl_en(ctl_en), .blk_en(blk_en),
      .iso_en(iso_en)
   );

   always #4 clk = ~clk;

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int m_ratio, m_per, m_ctl, m_iso, m_blk, m_state, m_route, m_conn, m_wen;
   int m_cnt, m_sof, m_seen, m_iso_act, m_s1, m_s2, mv_ms, mv_evt, mv_first, mv_entry;
   bit m_live = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ratio = 0; m_per = 0; m_ctl = 0; m_iso = 0; m_blk = 0; m_state = 0;
         m_route = 0; m_conn = 0; m_wen = 0; m_cnt = 0; m_sof = 0; m_seen = 0;
         m_iso_act = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         mv_ms = m_state;
         mv_evt = m_s2; m_s2 = m_s1; m_s1 = int'(port_resume_det);
         mv_first = 0;
         if (mv_ms != 2) begin m_cnt = 0; m_sof = 0; end
         else if (m_sof == 0) begin
            if (m_cnt == N - 1) begin m_sof = 1; mv_first = 1; end
            else m_cnt++;
         end
         mv_entry = (!sw_rst && wr_en && wr_data[7:6] == 2'd2 && mv_ms != 2) ? 1 : 0;
         if (sw_rst || mv_entry != 0) m_seen = 0;
         else if (mv_first != 0) m_seen = 1;
         if (sw_rst) m_iso_act = 0;
         else if (frame_edge) m_iso_act = m_iso;
         if (sw_rst) begin
            m_ratio = 0; m_per = 0; m_ctl = 0; m_iso = 0; m_blk = 0; m_wen = 0; m_state = 3;
         end else if (wr_en) begin
            m_ratio = int'(wr_data[1:0]); m_per = int'(wr_data[2]); m_ctl = int'(wr_data[3]);
            m_iso = int'(wr_data[4]); m_blk = int'(wr_data[5]); m_state = int'(wr_data[7:6]);
            m_route = int'(wr_data[8]); m_conn = int'(wr_data[9]); m_wen = int'(wr_data[10]);
         end else if (mv_ms == 3 && mv_evt != 0) begin
            m_state = 1;
         end
      end
      m_live = 1;
   end

   always @(posedge clk) begin
      #2;
      if (m_live && !done) begin
         int exp_rd;
         exp_rd = m_ratio | (m_per << 2) | (m_ctl << 3) | (m_iso << 4) | (m_blk << 5) |
                  (m_state << 6) | (m_route << 8) | (m_conn << 9) | (m_wen << 10) | (m_seen << 11);
         chk(rd_data == 32'(exp_rd), "R1 model readback", rd_data, exp_rd);
         chk(func_state == 2'(m_state), "R4 model state", func_state, m_state);
         chk(sof_en == m_sof[0], "R5 model sof_en", sof_en, m_sof);
         chk(port_reset_req == (m_state == 0), "R2 model port reset", port_reset_req, m_state == 0);
         chk(remote_wake == (m_wen[0] & resume_status), "R10 model wake", remote_wake, m_wen[0] & resume_status);
         chk({irq_host, irq_smi} == {irq_req & ~m_route[0], irq_req & m_route[0]},
             "R9 model routing", {irq_host, irq_smi}, {irq_req & ~m_route[0], irq_req & m_route[0]});
         chk({svc_ratio, per_en, ctl_en, blk_en} == {m_ratio[1:0], m_per[0], m_ctl[0], m_blk[0]},
             "R11 model enables", {svc_ratio, per_en, ctl_en, blk_en},
             {m_ratio[1:0], m_per[0], m_ctl[0], m_blk[0]});
         chk(iso_en == m_iso_act[0], "R8 model iso_en", iso_en, m_iso_act);
      end
   end

   task automatic wr(input logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      chk(0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int k;
      repeat (3) @(negedge clk);
      chk(rd_data == 0, "R2 reset value", rd_data, 0);
      chk(func_state == 0, "R2 reset state", func_state, 0);
      chk(port_reset_req == 1, "R2 port reset in reset state", port_reset_req, 1);
      rst_n = 1'b1;

      wr(32'h325);
      irq_req = 1'b1;
      #1;
      chk(rd_data == 32'h325, "R1 readback", rd_data, 32'h325);
      chk(irq_smi && !irq_host, "R9 routed to system management", {irq_host, irq_smi}, 2'b01);
      chk(svc_ratio == 1 && per_en && !ctl_en && blk_en, "R11 enables", {svc_ratio, per_en, ctl_en, blk_en}, 5'b01101);

      wr(32'h3B5);
      chk(iso_en == 0, "R8 iso held before frame edge", iso_en, 0);
      k = 0;
      while (!sof_en && k < 1000) begin @(negedge clk); k++; end
      chk(k == N, "R5 start delay in cycles", k, N);
      chk(rd_data[11] == 1, "R7 frame-started flag set", rd_data[11], 1);

      @(negedge clk); frame_edge = 1'b1;
      @(negedge clk); frame_edge = 1'b0;
      chk(iso_en == 1, "R8 iso applied at frame edge", iso_en, 1);

      wr(32'h3B5);
      repeat (3) @(negedge clk);
      chk(sof_en == 1, "R5 rewrite does not restart", sof_en, 1);

      wr(32'h7F5);
      @(negedge clk);
      chk(sof_en == 0, "R6 sof off out of operational", sof_en, 0);
      chk(rd_data[11] == 1, "R7 flag sticky after leaving", rd_data[11], 1);
      resume_status = 1'b1;
      #1;
      chk(remote_wake == 1, "R10 wake with enable and status", remote_wake, 1);
      chk(irq_smi == 1, "R10 enable leaves interrupt alone", irq_smi, 1);

      port_resume_det = 1'b1;
      @(negedge clk); port_resume_det = 1'b0;
      repeat (3) @(negedge clk);
      chk(func_state == 1, "R4 suspend to resume on detection", func_state, 1);

      wr(32'h7B5);
      chk(rd_data[11] == 0, "R7 flag cleared on entry", rd_data[11], 0);
      repeat (5) @(negedge clk);
      wr(32'h775);
      repeat (N + 5) @(negedge clk);
      chk(sof_en == 0, "R6 cancelled pending start", sof_en, 0);

      @(negedge clk); sw_rst = 1'b1; wr_en = 1'b1; wr_data = 32'h0B5;
      @(negedge clk); sw_rst = 1'b0; wr_en = 1'b0;
      chk(func_state == 3, "R3 software reset to suspend", func_state, 3);
      chk(rd_data == 32'h3C0, "R3 keeps routing and connect bits", rd_data, 32'h3C0);
      chk(port_reset_req == 0, "R3 no port reset from software reset", port_reset_req, 0);

      @(negedge clk); rst_n = 1'b0;
      #1;
      chk(rd_data == 0, "R2 hardware reset clears all", rd_data, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(irq_host == 1, "R9 normal route after reset", irq_host, 1);
      finish_run();
   end
endmodule